// File: doc/BRIEF.md
# Two-Channel Programmable Interval Timer

This block provides two independent down-counting interval timers, named channel 0 and channel 2, that share one byte-wide write port. Software first writes a control byte that selects a channel and records a 3-bit mode for it. It then writes a 16-bit reload count as two bytes, low byte first, to a channel data address. Once loaded, the channel counts strobes on `tick_i`, which the system asserts for one clock per period of a 1.193180 MHz reference. The channel therefore expires every `count / 1193180` seconds. On each expiry it raises a one-clock pulse, sets a sticky status flag and restarts with the same count.

The two-byte load uses a single sequencer shared by both data addresses. The first data write, to either address, is held as the low byte. The second data write supplies the high byte and loads the channel whose address that second write used. A status byte per channel can be read combinationally. Control bytes that ask for anything other than low-then-high binary access to channel 0 or 2 are rejected and flagged.

The asynchronous active-low reset is released through a two-stage synchronizer, so the block starts acting on writes two clocks after `rst_n` rises.

Top module: `pit_pair`

## Requirements
- R1: After reset both status bytes read 0x00, `fire_o` is 0, `cw_err_o` is 0, and no channel counts until it is loaded.
- R2: A write to address 3 is a control byte. Bits 7:6 select the channel (0 = channel 0, 2 = channel 2). Bits 5:4 select the access mode. Bits 3:1 hold the mode, which is stored for the selected channel and read back in status bits 3:1.
- R3: A control byte is rejected when bits 5:4 are not 11, when bits 7:6 are 1 or 3, or when bit 0 (decimal counting) is 1. A rejected byte pulses `cw_err_o` for the one clock after the write and changes no mode.
- R4: Data writes go to address 0 (channel 0) or address 2 (channel 2). A single pending flag alternates between the two bytes of a load. The first data write stores the low byte. The second forms `low + 256*high` and loads the channel addressed by the second write, whichever address the first write used. The flag is then clear.
- R5: A loaded channel with count N (1 to 65535) pulses its `fire_o` bit (bit 0 = channel 0, bit 1 = channel 2) for one clock after every N-th tick strobe. It reloads N automatically, so later pulses follow every N ticks.
- R6: A count of 0 is taken as 65536 ticks.
- R7: The status byte is {2'b00, expired, 1'b0, mode[2:0], 1'b0}. The expired flag (bit 5, value 0x20) sets on the first expiry and clears when that channel is loaded again.
- R8: A write to address 1 has no effect, and it neither consumes nor disturbs a pending low byte. Reads of addresses 1 and 3 return 0x00.
- R9: The channels count independently. Loading or rewriting the mode of one channel does not alter the timing of the other.
- R10: A channel advances only on clocks with `tick_i` high. A load takes priority over a tick in the same clock, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock strobe at the 1.193180 MHz count rate |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 2 | Write address: 0 ch0 data, 1 unused, 2 ch2 data, 3 control |
| wr_data_i | input | 8 | Write data byte |
| rd_addr_i | input | 2 | Status read address: 0 ch0, 2 ch2 |
| rd_data_o | output | 8 | Status byte for the addressed channel, else 0x00 |
| fire_o | output | 2 | Expiry pulses; bit 0 channel 0, bit 1 channel 2 |
| cw_err_o | output | 1 | One-clock pulse after a rejected control byte |

## Verification
A write takes effect at the clock edge that samples it. The mode, the cleared expired flag and `cw_err_o` are therefore visible after that edge, and the status read path adds no delay. An expiry pulse and the expired flag appear after the edge that samples the N-th tick, and the pulse is gone one clock later. The bench drives inputs just after a rising edge and compares every output against its behavioural model at the falling edge. It measures expiry intervals in observed tick strobes, counting from one pulse to the next or from the end of a load to the first pulse.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam logic [1:0] ADDR_CH0  = 2'd0;
  localparam logic [1:0] ADDR_GAP  = 2'd1;
  localparam logic [1:0] ADDR_CH2  = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  localparam logic [1:0] ACC_LOHI  = 2'b11;
  localparam int         MODE_W    = 3;

  typedef struct packed {
    logic [1:0]        sel;
    logic [1:0]        acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctrl_word_t;

  // channel index -> select code / data address (0 -> 0, 1 -> 2)
  function automatic logic [1:0] chan_code(input int idx);
    return 2'(2 * idx);
  endfunction

  function automatic logic [7:0] status_byte(input logic expired,
                                             input logic [MODE_W-1:0] mode);
    return {2'b00, expired, 1'b0, mode, 1'b0};
  endfunction

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
  import pit_pkg::*;
#(
  parameter int CH_NUM = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [1:0]                     wr_addr_i,
  input  logic [7:0]                     wr_data_i,
  output logic [CH_NUM-1:0][MODE_W-1:0]  mode_o,
  output logic                           err_o
);

  ctrl_word_t                    cw;
  logic                          ctrl_wr;
  logic                          cw_ok;
  logic [CH_NUM-1:0]             hit;
  logic [CH_NUM-1:0][MODE_W-1:0] mode_q, mode_d;
  logic                          mode_en;
  logic                          err_q, err_d;

  assign cw      = ctrl_word_t'(wr_data_i);
  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_comb begin
    hit = '0;
    for (int i = 0; i < CH_NUM; i++) begin
      hit[i] = (cw.sel == chan_code(i));
    end
  end

  assign cw_ok   = (|hit) && (cw.acc == ACC_LOHI) && !cw.bcd;
  assign mode_en = ctrl_wr && cw_ok;
  assign err_d   = ctrl_wr && !cw_ok;

  always_comb begin
    mode_d = mode_q;
    for (int i = 0; i < CH_NUM; i++) begin
      if (hit[i]) mode_d[i] = cw.mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      err_q <= err_d;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  // R3: a rejected control byte leaves every mode as it was
  p_err_keeps_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(mode_q));

  // R2: a mode changes only after an accepted control write
  p_mode_needs_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(ctrl_wr));

endmodule

// File: rtl/pit_load_seq.sv
module pit_load_seq
  import pit_pkg::*;
#(
  parameter int CH_NUM = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [CH_NUM-1:0] load_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam int HI_W = CNT_W - 8;

  logic              pend_q, pend_d;
  logic [7:0]        low_q;
  logic              low_en;
  logic [CH_NUM-1:0] addr_hit;
  logic              data_wr;

  always_comb begin
    addr_hit = '0;
    for (int i = 0; i < CH_NUM; i++) begin
      addr_hit[i] = (wr_addr_i == chan_code(i));
    end
  end

  assign data_wr = wr_en_i && (|addr_hit);

  always_comb begin
    pend_d = pend_q;
    low_en = 1'b0;
    load_o = '0;
    if (data_wr) begin
      if (!pend_q) begin
        low_en = 1'b1;
        pend_d = 1'b1;
      end else begin
        pend_d = 1'b0;
        load_o = addr_hit;
      end
    end
  end

  assign count_o = {wr_data_i[HI_W-1:0], low_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      low_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (low_en) low_q <= wr_data_i;
    end
  end

  // R4: a load only completes a pending pair, and the pair is closed after it
  p_load_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_o) |-> pend_q);
  p_pend_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_o) |=> !pend_q);
  p_load_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o));

  // R8: the unused address leaves the sequencer untouched
  p_gap_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == ADDR_GAP) |=> ($stable(pend_q) && $stable(low_q)));

endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             fire_o,
  output logic             expired_o
);

  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] FULL_SPAN = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] rld_q;
  logic [CW-1:0] load_val;
  logic          run_q, run_d;
  logic          exp_q, exp_d;
  logic          fire_q, fire_d;
  logic          cnt_en;

  assign load_val = (count_i == '0) ? FULL_SPAN : {1'b0, count_i};
  assign cnt_en   = load_i || (run_q && tick_i);

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    exp_d  = exp_q;
    fire_d = 1'b0;
    if (load_i) begin
      cnt_d = load_val;
      run_d = 1'b1;
      exp_d = 1'b0;
    end else if (run_q && tick_i) begin
      if (cnt_q == ONE) begin
        cnt_d  = rld_q;
        fire_d = 1'b1;
        exp_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      run_q  <= 1'b0;
      exp_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (load_i) rld_q <= load_val;
      run_q  <= run_d;
      exp_q  <= exp_d;
      fire_q <= fire_d;
    end
  end

  assign fire_o    = fire_q;
  assign expired_o = exp_q;

  // R10: an expiry needs a counted tick in the previous clock, not a load
  p_fire_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> ($past(tick_i) && !$past(load_i)));

  // R7: the pulse always comes with the expired flag
  p_fire_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> exp_q);

  // R7: a load clears the flag and starts the channel
  p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!exp_q && !fire_q && run_q));

  // R6: a running count stays within 1 .. reload (reload up to 65536)
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0 && cnt_q <= rld_q && rld_q <= FULL_SPAN));

endmodule

// File: rtl/pit_pair.sv
module pit_pair
  import pit_pkg::*;
#(
  parameter int CH_NUM = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [CH_NUM-1:0] fire_o,
  output logic              cw_err_o
);

  logic [1:0]                    rst_sync_q;
  logic                          rst_n_int;
  logic [CH_NUM-1:0][MODE_W-1:0] mode;
  logic [CH_NUM-1:0]             load;
  logic [CNT_W-1:0]              count;
  logic [CH_NUM-1:0]             expired;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  pit_ctrl_decode #(.CH_NUM(CH_NUM)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode),
    .err_o     (cw_err_o)
  );

  pit_load_seq #(.CH_NUM(CH_NUM), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_o    (load),
    .count_o   (count)
  );

  generate
    for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
      pit_channel #(.CNT_W(CNT_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n_int),
        .tick_i    (tick_i),
        .load_i    (load[g]),
        .count_i   (count),
        .fire_o    (fire_o[g]),
        .expired_o (expired[g])
      );
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < CH_NUM; i++) begin
      if (rd_addr_i == chan_code(i)) rd_data_o = status_byte(expired[i], mode[i]);
    end
  end

  // R3: the error pulse only follows a control-address write
  p_err_after_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    cw_err_o |-> ($past(wr_en_i) && $past(wr_addr_i) == ADDR_CTRL));

  // R9: a load reaches only the channel it addresses
  p_load_single_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    $countones(load) <= 1);

endmodule

// File: tb/sim_pit_pair.sv
module sim_pit_pair;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [1:0] rd_addr_i = 2'd0;
  logic [7:0] rd_data_o;
  logic [1:0] fire_o;
  logic       cw_err_o;

  always #4 clk = ~clk;   // 125 MHz

  pit_pair u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .fire_o(fire_o), .cw_err_o(cw_err_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tick_per = 0;
  int tick_total = 0;
  int fire_cnt [2];

  // behavioural reference model
  int m_cnt [2];
  int m_rld [2];
  bit m_run [2];
  bit m_exp [2];
  bit m_fire [2];
  int m_mode [2];
  bit m_pend;
  int m_low;
  bit m_err;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic int exp_status(int a);
    if (a == 0) return (int'(m_exp[0]) << 5) | (m_mode[0] << 1);
    if (a == 2) return (int'(m_exp[1]) << 5) | (m_mode[1] << 1);
    return 0;
  endfunction

  always @(posedge clk) begin
    int ld;
    int val;
    int sel;
    cyc++;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_rld[c] = 0; m_run[c] = 0; m_exp[c] = 0;
        m_fire[c] = 0; m_mode[c] = 0; fire_cnt[c] = 0;
      end
      m_pend = 0; m_low = 0; m_err = 0;
    end else begin
      if (tick_i) tick_total++;
      m_err = 0;
      ld = -1;
      val = 0;
      for (int c = 0; c < 2; c++) m_fire[c] = 0;
      if (wr_en_i) begin
        if (wr_addr_i == 2'd3) begin
          sel = int'(wr_data_i[7:6]);
          if (wr_data_i[5:4] == 2'b11 && !wr_data_i[0] && (sel == 0 || sel == 2))
            m_mode[sel / 2] = int'(wr_data_i[3:1]);
          else
            m_err = 1;
        end else if (wr_addr_i != 2'd1) begin
          if (!m_pend) begin
            m_low = int'(wr_data_i);
            m_pend = 1;
          end else begin
            m_pend = 0;
            ld = int'(wr_addr_i) / 2;
            val = m_low + 256 * int'(wr_data_i);
          end
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (c == ld) begin
          m_rld[c] = (val == 0) ? 65536 : val;
          m_cnt[c] = m_rld[c];
          m_run[c] = 1;
          m_exp[c] = 0;
        end else if (m_run[c] && tick_i) begin
          if (m_cnt[c] == 1) begin
            m_fire[c] = 1;
            m_exp[c] = 1;
            m_cnt[c] = m_rld[c];
          end else begin
            m_cnt[c]--;
          end
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && cyc > 4) begin
      chk("R5 fire ch0", int'(fire_o[0]), int'(m_fire[0]));
      chk("R5 fire ch2", int'(fire_o[1]), int'(m_fire[1]));
      chk("R3 cw_err", int'(cw_err_o), int'(m_err));
      chk("R7 status read", int'(rd_data_o), exp_status(int'(rd_addr_i)));
      if (fire_o[0]) fire_cnt[0]++;
      if (fire_o[1]) fire_cnt[1]++;
    end
  end

  // tick strobe generator
  always @(posedge clk) begin
    #1;
    tick_i = (tick_per > 0) && ((cyc % tick_per) == 0);
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 195000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 195000);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic set_rd(input logic [1:0] a);
    @(posedge clk); #1;
    rd_addr_i = a;
    @(negedge clk);
  endtask

  task automatic wait_fire(input int c);
    do @(negedge clk); while (!fire_o[c]);
  endtask

  task automatic interval(input int c, input int n, input string tag);
    int t0;
    wait_fire(c);
    t0 = tick_total;
    wait_fire(c);
    chk(tag, tick_total - t0, n);
  endtask

  initial begin
    int t0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1: reset state
    set_rd(2'd0);
    chk("R1 status ch0 after reset", int'(rd_data_o), 0);
    chk("R1 fire after reset", int'(fire_o), 0);
    chk("R1 cw_err after reset", int'(cw_err_o), 0);
    set_rd(2'd2);
    chk("R1 status ch2 after reset", int'(rd_data_o), 0);

    // R2: accepted control bytes
    wr(2'd3, 8'h36);
    set_rd(2'd0);
    chk("R2 mode ch0 = 3", int'(rd_data_o), 8'h06);
    wr(2'd3, 8'hB4);
    set_rd(2'd2);
    chk("R2 mode ch2 = 2", int'(rd_data_o), 8'h04);

    // R3: rejected control bytes
    wr(2'd3, 8'h26);
    chk("R3 err for access 10", int'(cw_err_o), 1);
    wr(2'd3, 8'hFE);
    chk("R3 err for read-back", int'(cw_err_o), 1);
    wr(2'd3, 8'h7E);
    chk("R3 err for select 1", int'(cw_err_o), 1);
    wr(2'd3, 8'h3F);
    chk("R3 err for decimal", int'(cw_err_o), 1);
    set_rd(2'd0);
    chk("R3 mode ch0 kept", int'(rd_data_o), 8'h06);
    wr(2'd3, 8'h3E);
    chk("R2 no err for valid byte", int'(cw_err_o), 0);
    set_rd(2'd0);
    chk("R2 mode ch0 = 7", int'(rd_data_o), 8'h0E);

    // R10: loaded but no ticks -> no expiry
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h00);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R10 no tick no fire", fire_cnt[0], 0);

    // R5: period 5 ticks, strobe every 3 clocks
    tick_per = 3;
    interval(0, 5, "R5 ch0 interval 5");
    interval(0, 5, "R5 ch0 interval 5 again");
    set_rd(2'd0);
    chk("R7 ch0 expired flag", int'(rd_data_o), 8'h2E);

    // R8: unused address inside a pair
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h00);
    interval(1, 3, "R8 ch2 interval 3 after gap write");
    set_rd(2'd2);
    chk("R7 ch2 expired flag", int'(rd_data_o), 8'h24);
    set_rd(2'd1);
    chk("R8 read addr 1", int'(rd_data_o), 0);
    set_rd(2'd3);
    chk("R8 read addr 3", int'(rd_data_o), 0);

    // R4: pair split across addresses loads the second address (ch2 <- 4)
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h00);
    set_rd(2'd2);
    chk("R7 ch2 flag cleared by load", int'(rd_data_o), 8'h04);
    interval(1, 4, "R4 ch2 interval 4 from shared pair");
    interval(0, 5, "R9 ch0 still interval 5");

    // R6: count 0 -> 65536 ticks, strobe every clock
    tick_per = 1;
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h00);
    t0 = tick_total;
    wait_fire(0);
    chk("R6 first expiry at 65536", tick_total - t0, 65536);

    repeat (4) @(posedge clk);
    summary();
    $finish;
  end

endmodule